// File: doc/BRIEF.md
# Phase Step Controller

The controller sits in the clock domain that drives the fine phase adjustment port of a clock manager. It takes a signed target offset, counted in delay steps, and walks the manager toward that offset one step at a time. Each step is a one-cycle enable strobe with a direction line: high adds a step, low removes one. After each strobe the controller waits for the manager's one-cycle completion pulse. That pulse can arrive many cycles later, after a variable delay. Only then does the controller decide on the next step.

The tracked offset changes only when a completion pulse is accepted, so it always shows steps that have really been applied. The target is saturated to a symmetric range of plus or minus `MAX_STEPS` before any stepping begins. A watchdog counter stops a wait that takes too long. It abandons the outstanding step, raises an error flag that stays set until reset, and lets the controller issue a fresh request. Reset puts the tracked offset back to zero, which matches a manager that also returns to zero phase on reset.

Top module: `phase_step_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `cur_pos` is 0, `step_en` is low and `timeout_err` is low. `rst` is synchronous and active high.
- R2: `step_en` is never high on two consecutive cycles. After a strobe, no further strobe is issued until a completion pulse has been accepted or the wait has timed out.
- R3: While `step_en` is high, `step_up` is 1 if the saturated target is above `cur_pos` and 0 if it is below.
- R4: `cur_pos` changes only on the cycle after `step_done` is seen high while a step is outstanding. It changes by +1 when that step had `step_up` = 1 and by -1 otherwise. A `step_done` pulse with no step outstanding has no effect.
- R5: The target is saturated to the range -`MAX_STEPS` to +`MAX_STEPS`. `cur_pos` never leaves that range, and it settles at the saturated target.
- R6: `busy` is high whenever a step is outstanding or `cur_pos` differs from the saturated target. It is low otherwise.
- R7: If `step_done` does not arrive within `TIMEOUT` cycles of waiting, the step is abandoned and `cur_pos` is left unchanged. `timeout_err` goes high and stays high until reset, and the controller then retries the step.
- R8: Once `cur_pos` equals the saturated target and no step is outstanding, no strobe is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase adjustment clock |
| rst | input | 1 | Synchronous active-high reset; offset returns to zero |
| target | input | POS_W | Signed requested offset in steps |
| step_done | input | 1 | One-cycle completion pulse from the clock manager |
| step_en | output | 1 | One-cycle step request strobe |
| step_up | output | 1 | Direction of the request: 1 adds a step, 0 removes one |
| cur_pos | output | POS_W | Signed offset made of completed steps |
| busy | output | 1 | Stepping in progress or target not yet reached |
| timeout_err | output | 1 | Sticky flag: a completion pulse was missed |

## Verification
The bench builds the controller with `POS_W` = 8, `MAX_STEPS` = 20 and `TIMEOUT` = 40. With these values, targets of ±100 can be driven inside the 8-bit signed range and show saturation at both ends. The timeout is short enough that a withheld completion pulse trips it within a few dozen cycles. A bench-side responder returns completion after latencies from 1 to 9 cycles, so both the fastest step rhythm and long waits are covered. The responder can also drop requests completely, which drives the timeout and retry path.

// File: rtl/phase_step_ctrl.sv
module phase_step_ctrl #(
  parameter int POS_W     = 12,
  parameter int MAX_STEPS = 1000,
  parameter int TIMEOUT   = 1024
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [POS_W-1:0] target,
  input  logic                    step_done,
  output logic                    step_en,
  output logic                    step_up,
  output logic signed [POS_W-1:0] cur_pos,
  output logic                    busy,
  output logic                    timeout_err
);

  localparam int TW = $clog2(TIMEOUT + 1);
  localparam logic signed [POS_W-1:0] LIM_HI = POS_W'(MAX_STEPS);
  localparam logic signed [POS_W-1:0] LIM_LO = -LIM_HI;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} st_t;

  st_t                     st;
  logic [TW-1:0]           tmr;
  logic signed [POS_W-1:0] goal;
  logic                    at_goal;
  logic                    tmo_hit;

  assign goal    = (target > LIM_HI) ? LIM_HI :
                   (target < LIM_LO) ? LIM_LO : target;
  assign at_goal = (goal == cur_pos);
  assign tmo_hit = (tmr == TW'(TIMEOUT - 1));
  assign step_en = (st == S_REQ);
  assign busy    = (st != S_IDLE) || !at_goal;

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= S_IDLE;
      tmr         <= '0;
      cur_pos     <= '0;
      step_up     <= 1'b0;
      timeout_err <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (!at_goal) begin
          st      <= S_REQ;
          step_up <= (goal > cur_pos);
        end
        S_REQ: begin
          st  <= S_WAIT;
          tmr <= '0;
        end
        S_WAIT: begin
          if (step_done) begin
            cur_pos <= step_up ? cur_pos + POS_W'(1) : cur_pos - POS_W'(1);
            st      <= S_IDLE;
          end else if (tmo_hit) begin
            timeout_err <= 1'b1;
            st          <= S_IDLE;
          end else begin
            tmr <= tmr + TW'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/phase_step_ctrl_chk.sv
module phase_step_ctrl_chk #(
  parameter int POS_W     = 12,
  parameter int MAX_STEPS = 1000
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    step_done,
  input logic                    step_en,
  input logic                    step_up,
  input logic signed [POS_W-1:0] cur_pos,
  input logic                    busy,
  input logic                    timeout_err
);

  localparam logic signed [POS_W-1:0] HI = POS_W'(MAX_STEPS);

  // R2
  single_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    step_en |=> !step_en);

  // R4
  pos_on_done_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(cur_pos) |-> $past(step_done));

  // R4
  pos_unit_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(cur_pos) |-> (cur_pos - $past(cur_pos) == POS_W'(1)) ||
                          ($past(cur_pos) - cur_pos == POS_W'(1)));

  // R5
  pos_range_chk: assert property (@(posedge clk) disable iff (rst)
    (cur_pos <= HI) && (cur_pos >= -HI));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !step_en);

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    timeout_err |=> timeout_err);

  // R3
  dir_hold_chk: assert property (@(posedge clk) disable iff (rst)
    step_en |=> $stable(step_up));

endmodule

bind phase_step_ctrl phase_step_ctrl_chk #(
  .POS_W(POS_W),
  .MAX_STEPS(MAX_STEPS)
) chk_i (
  .clk(clk),
  .rst(rst),
  .step_done(step_done),
  .step_en(step_en),
  .step_up(step_up),
  .cur_pos(cur_pos),
  .busy(busy),
  .timeout_err(timeout_err)
);

// File: tb/tb_phase_step_ctrl.sv
`timescale 1ns/1ps
module tb_phase_step_ctrl;
  localparam int PW = 8;
  localparam int MX = 20;
  localparam int TO = 40;
  localparam int NV = 8;
  localparam int VT [NV] = '{5, -3, 30, -100, 0, 20, 21, -20};
  localparam int VE [NV] = '{5, -3, 20, -20, 0, 20, 20, -20};
  localparam int VL [NV] = '{1, 3, 1, 2, 9, 4, 1, 5};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic signed [PW-1:0] target = '0;
  logic step_done, step_en, step_up, busy, timeout_err;
  logic signed [PW-1:0] cur_pos;
  logic resp_done = 1'b0, spur = 1'b0, drop = 1'b0;
  int lat = 1, pend = 0, n_up = 0, n_dn = 0, checks = 0, errors = 0;
  bit outstanding = 0, prev_en = 0, done_flag = 0;

  assign step_done = resp_done | spur;

  phase_step_ctrl #(.POS_W(PW), .MAX_STEPS(MX), .TIMEOUT(TO)) dut (
    .clk(clk), .rst(rst), .target(target), .step_done(step_done),
    .step_en(step_en), .step_up(step_up), .cur_pos(cur_pos),
    .busy(busy), .timeout_err(timeout_err));

  always #2 clk = ~clk;

  function automatic int sat(int v);
    return v > MX ? MX : (v < -MX ? -MX : v);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // bench responder and monitor, on the falling edge
  always @(negedge clk) begin
    resp_done = 1'b0;
    if (!rst && step_en) begin
      chk(!prev_en, "R2 consecutive strobe", 1, 0);
      chk(!outstanding, "R2 strobe while outstanding", 1, 0);
      chk(step_up == (sat(int'(target)) > int'(cur_pos)), "R3 direction",
          int'(step_up), int'(sat(int'(target)) > int'(cur_pos)));
      if (step_up) n_up++; else n_dn++;
      if (!drop) begin
        outstanding = 1;
        pend = lat;
      end
    end else if (pend > 0) begin
      pend--;
      if (pend == 0) begin
        resp_done = 1'b1;
        outstanding = 0;
      end
    end
    prev_en = step_en;
  end

  task automatic settle(int limit);
    int n = 0;
    while (busy && n < limit) begin
      @(negedge clk);
      n++;
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int prev = 0;
    repeat (3) @(negedge clk);
    chk(cur_pos == 0, "R1 reset pos", int'(cur_pos), 0);
    chk(!step_en && !timeout_err, "R1 reset outputs", int'(step_en), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(cur_pos == 0 && !busy && !step_en, "R1 after release", int'(cur_pos), 0);

    for (int i = 0; i < NV; i++) begin
      lat = VL[i];
      n_up = 0; n_dn = 0;
      target = PW'(VT[i]);
      #0;
      chk(busy == (VE[i] != prev), "R6 busy on new target", int'(busy), int'(VE[i] != prev));
      settle(2000);
      chk(cur_pos == PW'(VE[i]), "R5 settled saturated pos", int'(cur_pos), VE[i]);
      chk(n_up == (VE[i] > prev ? VE[i] - prev : 0), "R4 up steps", n_up,
          VE[i] > prev ? VE[i] - prev : 0);
      chk(n_dn == (VE[i] < prev ? prev - VE[i] : 0), "R4 down steps", n_dn,
          VE[i] < prev ? prev - VE[i] : 0);
      chk(!busy && !timeout_err, "R6 idle after settle", int'(busy), 0);
      prev = VE[i];
    end

    // R4: stray completion while idle is ignored
    n_up = 0; n_dn = 0;
    spur = 1'b1; @(negedge clk); spur = 1'b0;
    repeat (4) @(negedge clk);
    chk(cur_pos == PW'(prev), "R4 stray done ignored", int'(cur_pos), prev);
    chk(n_up + n_dn == 0, "R8 no strobe when settled", n_up + n_dn, 0);

    // R7: missing completion trips timeout, position held, retry follows
    drop = 1'b1;
    target = PW'(prev + 1);
    repeat (TO + 8) @(negedge clk);
    chk(timeout_err == 1'b1, "R7 timeout flagged", int'(timeout_err), 1);
    chk(cur_pos == PW'(prev), "R7 pos held on timeout", int'(cur_pos), prev);
    chk(busy == 1'b1, "R6 busy while unresolved", int'(busy), 1);
    drop = 1'b0;
    settle(2000);
    chk(cur_pos == PW'(prev + 1), "R7 retry completes", int'(cur_pos), prev + 1);
    chk(timeout_err == 1'b1, "R7 flag sticky", int'(timeout_err), 1);

    // R1: reset clears position and flag
    target = '0;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cur_pos == 0, "R1 reset returns pos", int'(cur_pos), 0);
    chk(!timeout_err, "R1 reset clears flag", int'(timeout_err), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule